// File: doc/BRIEF.md
# Operand Fetch Mode Sequencer

This block sits between effective-address calculation and the execution stage of a sequential processor. Once the effective address (EA) is ready, the block takes a 3-bit access code from the instruction decode table. The code decides whether the operand comes from memory, from the EA itself or from the accumulator. It also decides whether the location must first be proven writable, and whether the next instruction word at PC+1 should be prefetched.

The block issues at most one operand request on its memory port and holds it until acknowledge or page fail. When the operand is in place, it pulses an execute strobe. Instruction prefetches go out on a separate fetch port, and a busy flag covers each prefetch until it completes. A page fail seen while the block waits drops the request and raises a trap strobe instead of the execute strobe. The operand register is left untouched in that case.

Top module: `opfetch_seq`

## Requirements
- R1: After reset, mem_req is 0 (none), exec_go, trap_go, fetch_req and prefetch_busy are low, and opnd is zero.
- R2: A start with code 0 issues no memory request and no fetch. exec_go pulses for one cycle, one cycle after the start edge, with opnd equal to EA zero-extended to the data width.
- R3: A start with code 1 behaves as code 0. In addition, fetch_req pulses in the same cycle as exec_go, with fetch_addr = PC+1 modulo 2^AW.
- R4: A start with code 2 issues no memory request. exec_go pulses two cycles after the start edge, with opnd equal to the zero-extended EA.
- R5: A start with code 3 drives mem_req = 2 (write test) with mem_addr = EA from the cycle after the start edge. One cycle after mem_ack, exec_go pulses and opnd holds the ac_data value sampled with mem_ack.
- R6: Codes 4 to 7 read EA. Codes 4 and 5 use mem_req = 1 (read) and code 6 uses 3 (read with write test). Code 7 uses 4 (read-pause-write) when uncached was high at start, and 3 otherwise. One cycle after mem_ack, exec_go pulses with opnd equal to the mem_rdata sampled with mem_ack.
- R7: Code 5 pulses fetch_req with fetch_addr = PC+1 in the same cycle as exec_go. The PC is the one sampled at start. Codes 0 and 2 to 4 and 6 to 7 never raise fetch_req.
- R8: prefetch_busy rises with fetch_req and stays high until the cycle after fetch_ack.
- R9: A page_fail while a memory request is outstanding, or during the code-2 wait step, gives a one-cycle trap_go in the next cycle. In that same cycle mem_req is 0, exec_go stays low and opnd keeps its prior value.
- R10: A start asserted while a request is outstanding is ignored.
- R11: mem_req and mem_addr stay stable while a request waits for mem_ack.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | EA ready, begin operand phase |
| acode | input | 3 | Access code from decode table |
| ea | input | AW | Effective address |
| pc | input | AW | Address of current instruction |
| uncached | input | 1 | EA is an uncached location |
| ac_data | input | DW | Accumulator value |
| mem_req | output | 3 | Operand request type |
| mem_addr | output | AW | Operand request address |
| mem_ack | input | 1 | Operand request complete |
| mem_rdata | input | DW | Read data, valid with mem_ack |
| page_fail | input | 1 | Paging check failed |
| fetch_req | output | 1 | Instruction prefetch request pulse |
| fetch_addr | output | AW | Prefetch address |
| fetch_ack | input | 1 | Prefetch complete |
| opnd | output | DW | Operand register |
| prefetch_busy | output | 1 | Prefetch outstanding |
| exec_go | output | 1 | Start execution pulse |
| trap_go | output | 1 | Divert to page-fail trap pulse |

## Verification
A wrong sequencer state shows at the ports within one cycle. Either the request type on mem_req is not the one its code calls for, or exec_go arrives a cycle early or late against a fixed count from start or mem_ack. A corrupted per-operation record shows one cycle after acknowledge: opnd picks the wrong source, or fetch_req fires for a code that must not prefetch. A stuck prefetch flag shows as prefetch_busy still high in the cycle after fetch_ack.

// File: rtl/opf_pkg.sv
package opf_pkg;
   typedef enum logic [2:0] {
      MQ_NONE    = 3'd0,
      MQ_READ    = 3'd1,
      MQ_WTEST   = 3'd2,
      MQ_READ_WT = 3'd3,
      MQ_RPW     = 3'd4
   } mreq_e;

   typedef enum logic [1:0] {
      SQ_IDLE = 2'd0,
      SQ_HOLD = 2'd1,
      SQ_WAIT = 2'd2
   } sq_state_e;

   typedef struct packed {
      logic  use_mem;
      mreq_e req;
      logic  pf_early;
      logic  pf_late;
      logic  hold;
      logic  take_ac;
   } acc_plan_t;
endpackage

// File: rtl/opf_decode.sv
module opf_decode
   import opf_pkg::*;
(
   input  logic [2:0] code,
   input  logic       uncached,
   output acc_plan_t  plan
);
   always_comb begin
      plan = '0;
      plan.req = MQ_NONE;
      case (code)
         3'd0: ;
         3'd1: plan.pf_early = 1'b1;
         3'd2: plan.hold = 1'b1;
         3'd3: begin
            plan.use_mem = 1'b1;
            plan.req     = MQ_WTEST;
            plan.take_ac = 1'b1;
         end
         3'd4: begin
            plan.use_mem = 1'b1;
            plan.req     = MQ_READ;
         end
         3'd5: begin
            plan.use_mem = 1'b1;
            plan.req     = MQ_READ;
            plan.pf_late = 1'b1;
         end
         3'd6: begin
            plan.use_mem = 1'b1;
            plan.req     = MQ_READ_WT;
         end
         default: begin
            plan.use_mem = 1'b1;
            plan.req     = uncached ? MQ_RPW : MQ_READ_WT;
         end
      endcase
   end
endmodule

// File: rtl/opf_prefetch.sv
module opf_prefetch #(
   parameter int AW = 10
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          launch,
   input  logic [AW-1:0] base_pc,
   input  logic          ack,
   output logic          fetch_req,
   output logic [AW-1:0] fetch_addr,
   output logic          busy
);
   localparam logic [AW-1:0] STEP = AW'(1);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         fetch_req  <= 1'b0;
         fetch_addr <= '0;
         busy       <= 1'b0;
      end else begin
         fetch_req <= launch;
         if (launch) begin
            fetch_addr <= base_pc + STEP;
            busy       <= 1'b1;
         end else if (ack) begin
            busy <= 1'b0;
         end
      end
   end
endmodule

// File: rtl/opfetch_seq.sv
module opfetch_seq
   import opf_pkg::*;
#(
   parameter int AW          = 10,
   parameter int DW          = 16,
   parameter bit EA_SIGN_EXT = 1'b0
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start,
   input  logic [2:0]    acode,
   input  logic [AW-1:0] ea,
   input  logic [AW-1:0] pc,
   input  logic          uncached,
   input  logic [DW-1:0] ac_data,
   output logic [2:0]    mem_req,
   output logic [AW-1:0] mem_addr,
   input  logic          mem_ack,
   input  logic [DW-1:0] mem_rdata,
   input  logic          page_fail,
   output logic          fetch_req,
   output logic [AW-1:0] fetch_addr,
   input  logic          fetch_ack,
   output logic [DW-1:0] opnd,
   output logic          prefetch_busy,
   output logic          exec_go,
   output logic          trap_go
);
   localparam int EXT_W = DW - AW;

   initial begin
      if (AW < 2)  $error("opfetch_seq: AW must be at least 2");
      if (DW < AW) $error("opfetch_seq: DW must not be below AW");
   end

   acc_plan_t plan_now, plan_q;
   sq_state_e state_q;
   mreq_e     req_q;
   logic [AW-1:0] addr_q, pc_q;
   logic [DW-1:0] ea_ext, ea_ext_q, opnd_q;
   logic          go_q, trap_q;
   logic          pf_launch;
   logic [AW-1:0] pf_base;
   logic          accept, mem_done, mem_fail;

   generate
      if (EXT_W == 0) begin : g_ext_none
         assign ea_ext = ea;
      end else if (EA_SIGN_EXT) begin : g_ext_sign
         assign ea_ext = {{EXT_W{ea[AW-1]}}, ea};
      end else begin : g_ext_zero
         assign ea_ext = {{EXT_W{1'b0}}, ea};
      end
   endgenerate

   opf_decode u_dec (
      .code     (acode),
      .uncached (uncached),
      .plan     (plan_now)
   );

   assign accept   = (state_q == SQ_IDLE) && start;
   assign mem_done = (state_q == SQ_WAIT) && mem_ack && !page_fail;
   assign mem_fail = (state_q != SQ_IDLE) && page_fail;

   assign pf_launch = (accept && plan_now.pf_early) || (mem_done && plan_q.pf_late);
   assign pf_base   = (state_q == SQ_IDLE) ? pc : pc_q;

   opf_prefetch #(.AW(AW)) u_pf (
      .clk        (clk),
      .rst_n      (rst_n),
      .launch     (pf_launch),
      .base_pc    (pf_base),
      .ack        (fetch_ack),
      .fetch_req  (fetch_req),
      .fetch_addr (fetch_addr),
      .busy       (prefetch_busy)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q  <= SQ_IDLE;
         req_q    <= MQ_NONE;
         addr_q   <= '0;
         pc_q     <= '0;
         ea_ext_q <= '0;
         opnd_q   <= '0;
         plan_q   <= '0;
         go_q     <= 1'b0;
         trap_q   <= 1'b0;
      end else begin
         go_q   <= 1'b0;
         trap_q <= 1'b0;
         case (state_q)
            SQ_IDLE: begin
               if (start) begin
                  plan_q   <= plan_now;
                  pc_q     <= pc;
                  ea_ext_q <= ea_ext;
                  if (plan_now.use_mem) begin
                     req_q   <= plan_now.req;
                     addr_q  <= ea;
                     state_q <= SQ_WAIT;
                  end else if (plan_now.hold) begin
                     state_q <= SQ_HOLD;
                  end else begin
                     go_q   <= 1'b1;
                     opnd_q <= ea_ext;
                  end
               end
            end
            SQ_HOLD: begin
               state_q <= SQ_IDLE;
               if (mem_fail) begin
                  trap_q <= 1'b1;
               end else begin
                  go_q   <= 1'b1;
                  opnd_q <= ea_ext_q;
               end
            end
            SQ_WAIT: begin
               if (mem_fail) begin
                  trap_q  <= 1'b1;
                  req_q   <= MQ_NONE;
                  state_q <= SQ_IDLE;
               end else if (mem_done) begin
                  go_q    <= 1'b1;
                  req_q   <= MQ_NONE;
                  opnd_q  <= plan_q.take_ac ? ac_data : mem_rdata;
                  state_q <= SQ_IDLE;
               end
            end
            default: state_q <= SQ_IDLE;
         endcase
      end
   end

   assign mem_req  = req_q;
   assign mem_addr = addr_q;
   assign opnd     = opnd_q;
   assign exec_go  = go_q;
   assign trap_go  = trap_q;
endmodule

// File: rtl/opfetch_seq_chk.sv
module opfetch_seq_chk #(
   parameter int AW = 10,
   parameter int DW = 16
) (
   input logic          clk,
   input logic          rst_n,
   input logic [2:0]    mem_req,
   input logic [AW-1:0] mem_addr,
   input logic          mem_ack,
   input logic          page_fail,
   input logic          fetch_req,
   input logic          prefetch_busy,
   input logic          fetch_ack,
   input logic          exec_go,
   input logic          trap_go,
   input logic [DW-1:0] opnd
);
   p_req_stable_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req != 3'd0 && !mem_ack && !page_fail) |=> ($stable(mem_req) && $stable(mem_addr)));

   p_ack_go_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req != 3'd0 && mem_ack && !page_fail) |=> (exec_go && mem_req == 3'd0));

   p_fail_trap_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req != 3'd0 && page_fail) |=> (trap_go && !exec_go && mem_req == 3'd0 && $stable(opnd)));

   p_busy_with_req_r8: assert property (@(posedge clk) disable iff (!rst_n)
      fetch_req |-> prefetch_busy);

   p_busy_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (prefetch_busy && fetch_ack && !fetch_req) |=> (!prefetch_busy || fetch_req));

   p_go_trap_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !(exec_go && trap_go));

   p_req_code_r6: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req <= 3'd4);
endmodule

bind opfetch_seq opfetch_seq_chk #(.AW(AW), .DW(DW)) u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .mem_req       (mem_req),
   .mem_addr      (mem_addr),
   .mem_ack       (mem_ack),
   .page_fail     (page_fail),
   .fetch_req     (fetch_req),
   .prefetch_busy (prefetch_busy),
   .fetch_ack     (fetch_ack),
   .exec_go       (exec_go),
   .trap_go       (trap_go),
   .opnd          (opnd)
);

// File: tb/opfetch_seq_tb.sv
module opfetch_seq_tb;
   localparam int AW = 10;
   localparam int DW = 16;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          start = 1'b0;
   logic [2:0]    acode = '0;
   logic [AW-1:0] ea = '0;
   logic [AW-1:0] pc = '0;
   logic          uncached = 1'b0;
   logic [DW-1:0] ac_data = '0;
   logic [2:0]    mem_req;
   logic [AW-1:0] mem_addr;
   logic          mem_ack = 1'b0;
   logic [DW-1:0] mem_rdata = '0;
   logic          page_fail = 1'b0;
   logic          fetch_req;
   logic [AW-1:0] fetch_addr;
   logic          fetch_ack = 1'b0;
   logic [DW-1:0] opnd;
   logic          prefetch_busy;
   logic          exec_go;
   logic          trap_go;

   int total = 0;
   int bad = 0;
   bit finished = 1'b0;
   logic [DW-1:0] exp_opnd = '0;

   always #5 clk = ~clk;

   opfetch_seq #(.AW(AW), .DW(DW)) u_dut (
      .clk(clk), .rst_n(rst_n), .start(start), .acode(acode), .ea(ea), .pc(pc),
      .uncached(uncached), .ac_data(ac_data), .mem_req(mem_req), .mem_addr(mem_addr),
      .mem_ack(mem_ack), .mem_rdata(mem_rdata), .page_fail(page_fail),
      .fetch_req(fetch_req), .fetch_addr(fetch_addr), .fetch_ack(fetch_ack),
      .opnd(opnd), .prefetch_busy(prefetch_busy), .exec_go(exec_go), .trap_go(trap_go)
   );

   task automatic chk(input bit ok, input string req, input longint act, input longint exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic finish_fetch();
      chk(prefetch_busy == 1'b1, "R8 busy held", prefetch_busy, 1);
      fetch_ack = 1'b1;
      @(negedge clk);
      fetch_ack = 1'b0;
      chk(prefetch_busy == 1'b0, "R8 busy cleared", prefetch_busy, 0);
   endtask

   task automatic run_op(input int code, input bit unc, input logic [AW-1:0] e,
                         input logic [AW-1:0] p, input int lat, input bit fail);
      logic [2:0]    exp_req;
      logic [DW-1:0] rd, acv;
      logic [AW-1:0] nxt;
      rd  = DW'((int'(e) * 7 + code * 4099 + lat) & 16'hFFFF);
      acv = ~rd;
      nxt = p + AW'(1);
      case (code)
         3: exp_req = 3'd2;
         4, 5: exp_req = 3'd1;
         6: exp_req = 3'd3;
         default: exp_req = unc ? 3'd4 : 3'd3;
      endcase
      @(negedge clk);
      start = 1'b1; acode = 3'(code); ea = e; pc = p; uncached = unc;
      @(negedge clk);
      start = 1'b0;
      pc = ~p; ea = ~e; uncached = ~unc;
      if (code <= 1) begin
         chk(exec_go == 1'b1, "R2 exec_go", exec_go, 1);
         chk(opnd == DW'(e), "R2 opnd", opnd, DW'(e));
         chk(mem_req == 3'd0, "R2 no request", mem_req, 0);
         chk(fetch_req == (code == 1), "R3 fetch_req", fetch_req, code == 1);
         exp_opnd = DW'(e);
         if (code == 1) begin
            chk(fetch_addr == nxt, "R3 fetch_addr", fetch_addr, nxt);
            @(negedge clk);
            chk(exec_go == 1'b0, "R2 single pulse", exec_go, 0);
            finish_fetch();
         end
      end else if (code == 2) begin
         chk(exec_go == 1'b0 && mem_req == 3'd0, "R4 wait step", exec_go, 0);
         page_fail = fail;
         @(negedge clk);
         page_fail = 1'b0;
         if (fail) begin
            chk(trap_go == 1'b1, "R9 trap from wait", trap_go, 1);
            chk(exec_go == 1'b0, "R9 no exec", exec_go, 0);
            chk(opnd == exp_opnd, "R9 opnd kept", opnd, exp_opnd);
         end else begin
            chk(exec_go == 1'b1, "R4 exec_go", exec_go, 1);
            chk(opnd == DW'(e), "R4 opnd", opnd, DW'(e));
            exp_opnd = DW'(e);
         end
      end else begin
         chk(mem_req == exp_req, (code == 3) ? "R5 req type" : "R6 req type", mem_req, exp_req);
         chk(mem_addr == e, "R5 mem_addr", mem_addr, e);
         for (int i = 0; i < lat; i++) begin
            if (i == 0) begin
               start = 1'b1; acode = 3'd0;
            end
            @(negedge clk);
            start = 1'b0;
            chk(mem_req == exp_req && mem_addr == e, "R11 request stable", mem_req, exp_req);
            chk(exec_go == 1'b0, "R10 start ignored", exec_go, 0);
         end
         mem_ack = ~fail; page_fail = fail; mem_rdata = rd; ac_data = acv;
         @(negedge clk);
         mem_ack = 1'b0; page_fail = 1'b0; mem_rdata = ~rd; ac_data = rd;
         chk(mem_req == 3'd0, "R9 request dropped", mem_req, 0);
         if (fail) begin
            chk(trap_go == 1'b1 && exec_go == 1'b0, "R9 trap", trap_go, 1);
            chk(opnd == exp_opnd, "R9 opnd kept", opnd, exp_opnd);
            chk(fetch_req == 1'b0, "R7 no fetch on fail", fetch_req, 0);
         end else begin
            exp_opnd = (code == 3) ? acv : rd;
            chk(exec_go == 1'b1, "R6 exec_go", exec_go, 1);
            chk(opnd == exp_opnd, (code == 3) ? "R5 opnd" : "R6 opnd", opnd, exp_opnd);
            chk(fetch_req == (code == 5), "R7 fetch_req", fetch_req, code == 5);
            if (code == 5) begin
               chk(fetch_addr == nxt, "R7 fetch_addr", fetch_addr, nxt);
               @(negedge clk);
               finish_fetch();
            end
         end
      end
      @(negedge clk);
      chk(exec_go == 1'b0 && trap_go == 1'b0, "R2 strobes idle", exec_go, 0);
      chk(mem_req == 3'd0, "R10 no stray request", mem_req, 0);
   endtask

   task automatic summary();
      if (!finished) begin
         finished = 1'b1;
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      total++;
      bad++;
      $display("FAIL watchdog actual=running expected=done");
      summary();
   end

   initial begin
      repeat (3) @(negedge clk);
      chk(mem_req == 3'd0 && exec_go == 1'b0 && trap_go == 1'b0, "R1 reset outputs", mem_req, 0);
      chk(fetch_req == 1'b0 && prefetch_busy == 1'b0, "R1 reset prefetch", prefetch_busy, 0);
      chk(opnd == '0, "R1 reset opnd", opnd, 0);
      rst_n = 1'b1;
      for (int c = 0; c < 8; c++)
         for (int u = 0; u < 2; u++)
            for (int l = 0; l < 3; l++)
               for (int f = 0; f < 2; f++)
                  run_op(c, u[0], AW'((c * 97 + l * 13 + u * 501 + f * 3) & 1023),
                         AW'((c * 211 + l * 5 + 17) & 1023), l, f[0] && c >= 2);
      run_op(1, 1'b0, 10'h3FF, 10'h3FF, 0, 1'b0);
      run_op(5, 1'b1, 10'h000, 10'h3FF, 1, 1'b0);
      run_op(7, 1'b1, 10'h3FF, 10'h200, 3, 1'b0);
      summary();
   end
endmodule